// File: doc/BRIEF.md
# Write-Buffered Forwarding Register File

This block is a register file with one write port and two combinational read ports. Reads behave as if the write of the same cycle had already landed, so a consumer sees a value in the cycle that produces it. Writes do not go straight into the storage array. Each accepted write is parked as an (index, data) pair in a one-entry search buffer. In the next cycle a drain step moves it into the plain storage array.

Each read port resolves its index in a fixed priority order. A matching write in the same cycle wins first. A matching buffered entry comes next. The array is used only when neither matches. Both read ports share one lookup design, instantiated once per port. The buffer can accept a new write in the same cycle it drains, so writes are taken every cycle without a stall. The write handshake still reports buffer space through `wr_ready`.

Top module: `wbuf_regfile`

## Requirements
- R1: While reset is asserted and after it is released, the buffer holds no entry and `wr_ready` is 1.
- R2: When `wr_valid` and `wr_ready` are both 1 and a read index equals `wr_idx`, that read port returns `wr_data` in the same cycle.
- R3: Once a write to index k is accepted, every later read of k returns the written data until another write to k is accepted. This holds in the cycle when the entry sits in the buffer and in every cycle after it has drained into the array.
- R4: The two read ports are independent. In one cycle, each returns the value of its own index, whether the indices are equal or different.
- R5: Writes issued on consecutive cycles are all accepted, with `wr_ready` staying 1. When several of them target the same index, the last one is the value seen afterwards.
- R6: A buffered entry drains in the cycle after it is accepted. If no new write arrives, the buffer is empty one cycle after the accepting edge.
- R7: A cycle with `wr_valid` low changes no stored value and does not forward `wr_data`, even when `wr_idx` matches a read index.
- R8: Reset clears only the buffer's valid flag. Array contents that drained before reset are still returned by reads after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Buffer can take a write this cycle |
| wr_idx | input | IDX_W | Register index to write |
| wr_data | input | DATA_W | Data to write |
| rd0_idx | input | IDX_W | Read port 0 index |
| rd0_data | output | DATA_W | Read port 0 data (combinational) |
| rd1_idx | input | IDX_W | Read port 1 index |
| rd1_data | output | DATA_W | Read port 1 data (combinational) |

## Verification
Two things can happen to the same index in the same cycle:
- a read of index k while a write to k is being accepted;
- a read of index k while the entry for k is still in the buffer and is being drained.

The bench provokes both. It aims reads at the index just written, in the same cycle and in the following cycle. It also writes the same index several times in a row. Each read is judged against a bench model in which a write takes effect before any read of its own cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // Which stage answered a read lookup.
    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_BUFFER = 2'd1,
        SRC_WRITE  = 2'd2
    } wbuf_src_e;

endpackage

// File: rtl/wbuf_entry.sv
// One-entry (index, data) holding buffer with same-cycle drain and refill.
module wbuf_entry #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [DATA_W-1:0] push_data,
    output logic              held_valid,
    output logic [IDX_W-1:0]  held_idx,
    output logic [DATA_W-1:0] held_data,
    output logic              drain_fire
);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  accept;

    always_comb begin
        slot_d     = slot_q;
        drain_fire = slot_q.valid;
        push_ready = !slot_q.valid || drain_fire;
        accept     = push_valid && push_ready;
        if (accept) begin
            slot_d.valid = 1'b1;
            slot_d.idx   = push_idx;
            slot_d.data  = push_data;
        end else if (drain_fire) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.valid <= 1'b0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign held_valid = slot_q.valid;
    assign held_idx   = slot_q.idx;
    assign held_data  = slot_q.data;

endmodule

// File: rtl/wbuf_store.sv
// Plain storage array: one write port fed by the drain, NUM_RD read ports.
module wbuf_store #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [IDX_W-1:0]               waddr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   raddr,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] mem_d [NUM_REGS];
    logic [DATA_W-1:0] mem_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end

endmodule

// File: rtl/wbuf_lookup.sv
// Per-port read resolution: same-cycle write, then buffer, then array.
module wbuf_lookup #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               wr_fire,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               buf_valid,
    input  logic [IDX_W-1:0]   buf_idx,
    input  logic [DATA_W-1:0]  buf_data,
    input  logic [DATA_W-1:0]  arr_data,
    output logic [DATA_W-1:0]  rd_data,
    output wbuf_pkg::wbuf_src_e rd_src
);
    import wbuf_pkg::*;

    always_comb begin
        if (wr_fire && (wr_idx == rd_idx)) begin
            rd_src = SRC_WRITE;
        end else if (buf_valid && (buf_idx == rd_idx)) begin
            rd_src = SRC_BUFFER;
        end else begin
            rd_src = SRC_ARRAY;
        end
        unique case (rd_src)
            SRC_WRITE:  rd_data = wr_data;
            SRC_BUFFER: rd_data = buf_data;
            default:    rd_data = arr_data;
        endcase
    end

endmodule

// File: rtl/wbuf_regfile.sv
// Top: write-buffered register file with same-cycle read forwarding.
module wbuf_regfile #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [DATA_W-1:0] rd1_data
);
    import wbuf_pkg::*;

    localparam int NUM_RD = 2;

    logic              buf_vld;
    logic [IDX_W-1:0]  buf_idx;
    logic [DATA_W-1:0] buf_dat;
    logic              drain;
    logic              wr_fire;

    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx_all;
    logic [NUM_RD-1:0][DATA_W-1:0] arr_dat_all;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_dat_all;
    wbuf_src_e                     rd_src_all [NUM_RD];

    assign wr_fire       = wr_valid && wr_ready;
    assign rd_idx_all[0] = rd0_idx;
    assign rd_idx_all[1] = rd1_idx;
    assign rd0_data      = rd_dat_all[0];
    assign rd1_data      = rd_dat_all[1];

    wbuf_entry #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (wr_valid),
        .push_ready (wr_ready),
        .push_idx   (wr_idx),
        .push_data  (wr_data),
        .held_valid (buf_vld),
        .held_idx   (buf_idx),
        .held_data  (buf_dat),
        .drain_fire (drain)
    );

    wbuf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_store (
        .clk   (clk),
        .we    (drain),
        .waddr (buf_idx),
        .wdata (buf_dat),
        .raddr (rd_idx_all),
        .rdata (arr_dat_all)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        wbuf_lookup #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_lookup (
            .rd_idx    (rd_idx_all[p]),
            .wr_fire   (wr_fire),
            .wr_idx    (wr_idx),
            .wr_data   (wr_data),
            .buf_valid (buf_vld),
            .buf_idx   (buf_idx),
            .buf_data  (buf_dat),
            .arr_data  (arr_dat_all[p]),
            .rd_data   (rd_dat_all[p]),
            .rd_src    (rd_src_all[p])
        );
    end

endmodule

// File: rtl/wbuf_regfile_chk.sv
// Property checker attached to the top module.
module wbuf_regfile_chk #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [IDX_W-1:0]  rd0_idx,
    input logic [DATA_W-1:0] rd0_data,
    input logic [IDX_W-1:0]  rd1_idx,
    input logic [DATA_W-1:0] rd1_data,
    input logic              buf_vld
);

    // R1 / R5: the write port is never stalled.
    assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready);

    // R2: same-cycle forwarding on both ports.
    assert_fwd0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && rd0_idx == wr_idx) |-> (rd0_data == wr_data));
    assert_fwd1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && rd1_idx == wr_idx) |-> (rd1_data == wr_data));

    // R3: a write is visible through the buffer in the following cycle.
    assert_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=>
            ((rd0_idx == $past(wr_idx) && !(wr_valid && wr_idx == rd0_idx))
             -> (rd0_data == $past(wr_data))));

    // R6: accept fills the buffer; an idle cycle drains it.
    assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> buf_vld);
    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !buf_vld);

endmodule

bind wbuf_regfile wbuf_regfile_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd0_idx  (rd0_idx),
    .rd0_data (rd0_data),
    .rd1_idx  (rd1_idx),
    .rd1_data (rd1_data),
    .buf_vld  (buf_vld)
);

// File: tb/tb_wbuf_regfile.sv
module tb_wbuf_regfile;
    localparam int NUM_REGS = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [IDX_W-1:0]  rd0_idx = '0;
    logic [DATA_W-1:0] rd0_data;
    logic [IDX_W-1:0]  rd1_idx = '0;
    logic [DATA_W-1:0] rd1_data;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [DATA_W-1:0] model [NUM_REGS];

    always #2.5 clk = ~clk;

    wbuf_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
    );

    function automatic logic [DATA_W-1:0] expect_rd(input logic [IDX_W-1:0] ri,
            input logic wv, input logic [IDX_W-1:0] wi, input logic [DATA_W-1:0] wd);
        if (wv && wi == ri) return wd;
        return model[ri];
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational reads, commit at posedge.
    task automatic step(input logic wv, input logic [IDX_W-1:0] wi,
                        input logic [DATA_W-1:0] wd, input logic [IDX_W-1:0] r0,
                        input logic [IDX_W-1:0] r1, input string req);
        @(negedge clk);
        wr_valid = wv; wr_idx = wi; wr_data = wd; rd0_idx = r0; rd1_idx = r1;
        #1;
        check({req, " rd0"}, rd0_data, expect_rd(r0, wv, wi, wd));
        check({req, " rd1"}, rd1_data, expect_rd(r1, wv, wi, wd));
        check("R5 ready", {31'd0, wr_ready}, 32'd1);
        @(posedge clk);
        if (wv) model[wi] = wd;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: ready during and after reset
        repeat (3) @(posedge clk);
        #1 check("R1 ready in reset", {31'd0, wr_ready}, 32'd1);
        @(negedge clk) rst_n = 1'b1;
        #1 check("R1 ready after reset", {31'd0, wr_ready}, 32'd1);

        // Fill every register; read the written index in the same cycle (R2)
        for (int i = 0; i < NUM_REGS; i++)
            step(1'b1, IDX_W'(i), $urandom, IDX_W'(i), IDX_W'(i), "R2 fill");
        step(1'b0, '0, '0, 0, 1, "R3 idle");

        // R3: buffer-hit cycle and array cycle
        step(1'b1, 5'd7, 32'hA5A5_0007, 5'd3, 5'd4, "R3 write");
        step(1'b0, '0, '0, 5'd7, 5'd7, "R3 from buffer");
        step(1'b0, '0, '0, 5'd7, 5'd6, "R3 from array");

        // R4: independent ports
        step(1'b1, 5'd9, 32'h1234_0009, 5'd9, 5'd2, "R4 split");
        step(1'b0, '0, '0, 5'd9, 5'd9, "R4 same");

        // R5: burst to same index, last wins
        step(1'b1, 5'd12, 32'h0000_0001, 5'd12, 5'd11, "R5 burst");
        step(1'b1, 5'd12, 32'h0000_0002, 5'd12, 5'd12, "R5 burst");
        step(1'b1, 5'd12, 32'h0000_0003, 5'd11, 5'd12, "R5 burst");
        step(1'b0, '0, '0, 5'd12, 5'd12, "R5 last wins");
        check("R5 value", model[12], 32'h0000_0003);

        // R7: write with valid low has no effect
        step(1'b0, 5'd15, 32'hDEAD_BEEF, 5'd15, 5'd15, "R7 no fwd");
        step(1'b0, '0, '0, 5'd15, 5'd14, "R7 unchanged");

        // R6: write then idle, then an immediately following read (drained)
        step(1'b1, 5'd20, 32'hCAFE_0020, 5'd0, 5'd1, "R6 write");
        step(1'b0, '0, '0, 5'd20, 5'd21, "R6 drain");
        step(1'b0, '0, '0, 5'd20, 5'd20, "R6 array");

        // R8: array survives reset after the entry has drained
        step(1'b1, 5'd25, 32'h2525_2525, 5'd0, 5'd0, "R8 write");
        step(1'b0, '0, '0, 5'd25, 5'd24, "R8 drain");
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, '0, '0, 5'd25, 5'd7, "R8 after reset");

        // Random mix: hits on the written index are biased up
        for (int n = 0; n < 600; n++) begin
            logic              wv;
            logic [IDX_W-1:0]  wi, r0, r1;
            logic [DATA_W-1:0] wd;
            wv = ($urandom % 4) != 0;
            wi = IDX_W'($urandom);
            wd = $urandom;
            r0 = (($urandom % 3) == 0) ? wi : IDX_W'($urandom);
            r1 = (($urandom % 3) == 0) ? wi : IDX_W'($urandom);
            step(wv, wi, wd, r0, r1, (wv && (r0 == wi || r1 == wi)) ? "R2 rand" : "R3 rand");
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule